// File: doc/BRIEF.md
# Staircase Sub-Converter Code Spreader

This block takes one digital sample and spreads it across a bank of identical 12-bit sub-converters whose analog outputs are summed outside the block. The sub-converters are filled one after another. Every slot below a boundary index gets the all-ones code. The slot at the boundary gets the low 12 bits of the sample. Every slot above the boundary gets zero. The summed output therefore climbs as a staircase of whole sub-converter ranges, with one converter covering the fine part.

The resolution is chosen at run time, from 12 to 16 bits. In a mode of R bits, the boundary index is the sample's bits [R-1:12], so only the first 2^(R-12) slots are ever used. Sample bits above the chosen resolution are discarded. The sample, the mode and a valid strobe are captured together. All sixteen slot codes come from registers and change on the same clock edge, so the slots never disagree.

Top module: `subdac_spread`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all sixteen slot codes are zero.
- R2: After a valid sample, every slot whose index is below the boundary index holds 12'hFFF.
- R3: After a valid sample, the slot at the boundary index holds code_in[11:0].
- R4: After a valid sample, every slot whose index is above the boundary index holds zero. This includes every slot at or beyond index 2^(R-12).
- R5: In a mode of R bits, the boundary index is code_in[R-1:12], read as an unsigned number. Bits code_in[15:R] have no effect on any slot.
- R6: res_mode selects the resolution as 12 + res_mode for values 0 to 4. Values 5 to 7 act as 16-bit mode.
- R7: In 12-bit mode (res_mode = 0), slot 0 holds code_in[11:0] and slots 1 to 15 hold zero.
- R8: Slot codes change only on a clock edge at which sample_valid is high. A change of res_mode or code_in while sample_valid is low has no effect. A mode sampled together with a valid strobe applies to that same sample.
- R9: Slot i occupies sub_codes[12*i+11 : 12*i], with slot 0 in the least significant bits.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Capture strobe for code_in and res_mode |
| res_mode | input | 3 | Resolution select: 12 + value bits, saturating at 16 |
| code_in | input | 16 | Input sample |
| sub_codes | output | 192 | Sixteen registered 12-bit slot codes, slot 0 in the low bits |

## Verification
Two functions can fall in the same cycle: a resolution change and a sample capture. The bench changes res_mode on the very edge that carries sample_valid. It then checks that the boundary comes from the new mode's bit field and not the old one. It also changes the mode with the strobe low and checks that the held slot codes do not move until the next valid sample.

// File: rtl/subdac_spread.sv
module subdac_spread #(
  parameter int SUB_W     = 12,
  parameter int EXTRA_MAX = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   sample_valid,
  input  logic [$clog2(EXTRA_MAX+1)-1:0]         res_mode,
  input  logic [SUB_W+EXTRA_MAX-1:0]             code_in,
  output logic [(SUB_W<<EXTRA_MAX)-1:0]          sub_codes
);
  localparam int NUM_SUB = 1 << EXTRA_MAX;
  localparam int MODE_W  = $clog2(EXTRA_MAX+1);

  logic [MODE_W-1:0]    extra;
  logic [EXTRA_MAX-1:0] sel_mask;
  logic [EXTRA_MAX-1:0] boundary;
  logic [SUB_W-1:0]     fine;

  assign extra    = (res_mode > MODE_W'(EXTRA_MAX)) ? MODE_W'(EXTRA_MAX) : res_mode;
  assign sel_mask = EXTRA_MAX'(((EXTRA_MAX+1)'(1) << extra) - (EXTRA_MAX+1)'(1));
  assign boundary = code_in[SUB_W +: EXTRA_MAX] & sel_mask;
  assign fine     = code_in[SUB_W-1:0];

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_slot
    logic [SUB_W-1:0] nxt;
    always_comb begin
      if (EXTRA_MAX'(i) < boundary)       nxt = '1;
      else if (EXTRA_MAX'(i) == boundary) nxt = fine;
      else                                nxt = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)            sub_codes[i*SUB_W +: SUB_W] <= '0;
      else if (sample_valid) sub_codes[i*SUB_W +: SUB_W] <= nxt;
    end
  end
endmodule

// File: rtl/subdac_spread_chk.sv
module subdac_spread_chk #(
  parameter int SUB_W     = 12,
  parameter int EXTRA_MAX = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           sample_valid,
  input logic [$clog2(EXTRA_MAX+1)-1:0] res_mode,
  input logic [SUB_W+EXTRA_MAX-1:0]     code_in,
  input logic [(SUB_W<<EXTRA_MAX)-1:0]  sub_codes
);
  localparam int NUM_SUB = 1 << EXTRA_MAX;

  logic [NUM_SUB-1:0] partial;
  logic [NUM_SUB-1:0] nonzero;
  logic [NUM_SUB-1:0] full;
  for (genvar i = 0; i < NUM_SUB; i++) begin : g_flag
    assign nonzero[i] = |sub_codes[i*SUB_W +: SUB_W];
    assign full[i]    = &sub_codes[i*SUB_W +: SUB_W];
    assign partial[i] = nonzero[i] && !full[i];
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sub_codes == '0));

  assert_one_fine_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(partial) <= 1);

  for (genvar i = 1; i < NUM_SUB; i++) begin : g_order
    assert_fill_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nonzero[i] |-> full[i-1]);
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(sub_codes));

  assert_narrow_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && res_mode == '0) |=>
      (sub_codes[SUB_W-1:0] == $past(code_in[SUB_W-1:0])) && (nonzero[NUM_SUB-1:1] == '0));

  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && res_mode == 1) |=> (nonzero[NUM_SUB-1:2] == '0));
endmodule

bind subdac_spread subdac_spread_chk #(.SUB_W(SUB_W), .EXTRA_MAX(EXTRA_MAX)) u_chk (.*);

// File: tb/subdac_spread_tb.sv
module subdac_spread_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         sample_valid = 0;
  logic [2:0]   res_mode = 0;
  logic [15:0]  code_in = 0;
  logic [191:0] sub_codes;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  subdac_spread u_dut (.clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
                       .res_mode(res_mode), .code_in(code_in), .sub_codes(sub_codes));

  function automatic logic [11:0] exp_slot(input logic [15:0] c, input logic [2:0] m, input int i);
    int r = (m > 3'd4) ? 4 : int'(m);
    int b = int'(c[15:12]) & ((1 << r) - 1);
    if (i < b)  return 12'hFFF;
    if (i == b) return c[11:0];
    return 12'h000;
  endfunction

  task automatic check_all(input logic [15:0] c, input logic [2:0] m, input string tag);
    bit bad = 0;
    tests++;
    for (int i = 0; i < 16; i++) begin
      logic [11:0] e = exp_slot(c, m, i);
      if (sub_codes[i*12 +: 12] !== e && !bad) begin
        bad = 1;
        fails++;
        $display("FAIL %s slot %0d code %h mode %0d: got %h exp %h", tag, i, c, m, sub_codes[i*12 +: 12], e);
      end
    end
  endtask

  task automatic apply(input logic [15:0] c, input logic [2:0] m, input string tag);
    @(negedge clk);
    code_in = c; res_mode = m; sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
    check_all(c, m, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    tests++;
    if (sub_codes !== '0) begin fails++; $display("FAIL R1 in reset: got %h exp 0", sub_codes); end
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (sub_codes !== '0) begin fails++; $display("FAIL R1 after reset: got %h exp 0", sub_codes); end

    apply(16'h0000, 3'd4, "R3 zero code");
    apply(16'hFFFF, 3'd4, "R2 full code");
    apply(16'hF000, 3'd4, "R3 top slot fine zero");
    apply(16'h7ABC, 3'd4, "R2/R3/R4 mid");
    apply(16'hFABC, 3'd0, "R7 narrow mode");
    apply(16'hF123, 3'd1, "R5 upper bits ignored 13b");
    apply(16'hE555, 3'd2, "R5 upper bits ignored 14b");
    apply(16'h9FFF, 3'd3, "R4 15b");
    apply(16'hB321, 3'd5, "R6 mode 5");
    apply(16'hC321, 3'd7, "R6 mode 7");

    apply(16'h5DEF, 3'd2, "R8 setup");
    @(negedge clk);
    res_mode = 3'd4; code_in = 16'hFFFF;
    repeat (2) @(negedge clk);
    check_all(16'h5DEF, 3'd2, "R8 hold without valid");
    apply(16'h5DEF, 3'd4, "R8 mode change with valid");

    tests++;
    if (sub_codes[11:0] !== 12'hFFF || sub_codes[71:60] !== 12'hDEF)
      begin fails++; $display("FAIL R9 field position: got %h/%h exp fff/def", sub_codes[11:0], sub_codes[71:60]); end

    for (int n = 0; n < 400; n++) begin
      logic [15:0] c = 16'($urandom());
      logic [2:0]  m = 3'($urandom_range(0, 7));
      apply(c, m, "R2/R3/R4/R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule